// File: doc/BRIEF.md
# Two-Wire Bus Lockup Recovery Sequencer

This block frees a two-wire serial bus that a slave device has left stuck, typically with the data line held low partway through a byte. When triggered, it takes the clock and data lines over through two override controls, each of which pulls its line low when set and releases it otherwise. It first toggles the clock nine times with data released, so that any slave still shifting out a byte runs to the end of it and lets go of the data line. It then builds a stop condition: both lines low, then clock released, then data released while clock is high.

Each step of the pattern lasts one half-period. The half-period is a parameter in system clock cycles, and about 5 µs is the usual setting for a standard-rate bus. When the pattern ends, both overrides return to released, which hands the lines back to the normal byte engine. A one-cycle completion pulse marks the end. The overrides also appear as bits of a register word at fixed positions, so that a neighbouring register file can read them back.

Top module: `bus_recover`

## Requirements
- R1: While reset is held and after it is released, the block is idle. Both overrides are released, busy is 0 and done is 0.
- R2: A trigger sampled high at a clock edge while the block is idle starts the sequence. From the next cycle on, busy is 1 and the first flush step is on the outputs.
- R3: Every step of the sequence stays on the outputs for exactly HALF_CYC clock cycles.
- R4: The flush consists of FLUSH_CNT pairs, 9 by default. Each pair is one step with both lines released, followed by one step with the clock override set and the data override clear.
- R5: After the last flush pair comes one step with both the clock and data overrides set.
- R6: Next comes one step with the clock override released and the data override still set, so the clock rises while data stays low.
- R7: Last comes one step with both overrides released, which forms a stop. In the cycle after that step, done is 1 for exactly one cycle, busy is 0 and the block is idle again.
- R8: A trigger that arrives while busy is 1 is ignored. The sequence continues unchanged and does not restart.
- R9: The override word has the data override at bit 8 and the clock override at bit 9, with all other bits 0. The pad enables scl_low_o and sda_low_o equal those bits, where 1 means pull the line low and 0 means release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery trigger, sampled at each clock edge |
| busy_o | output | 1 | High while the sequence runs |
| done_o | output | 1 | One-cycle pulse after the stop step |
| scl_low_o | output | 1 | Open-drain enable for the clock line: 1 pulls low, 0 releases |
| sda_low_o | output | 1 | Open-drain enable for the data line: 1 pulls low, 0 releases |
| ovr_word_o | output | REG_W | Override word: bit 9 is the clock override, bit 8 the data override |

## Verification
The bench builds the block with HALF_CYC = 3 and the default FLUSH_CNT of 9. At that size a full sequence is 63 cycles long, which allows every cycle of every run to be compared against a pattern the bench computes from the step index and the half-period. This covers each step boundary, the change from the last flush pair to the stop pattern, and the done pulse. Runs are repeated with triggers injected throughout the sequence and with back-to-back restarts, which exercises the ignore rule and the return to idle.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH_REL,
        PH_FLUSH_LOW,
        PH_BOTH_LOW,
        PH_DATA_HOLD,
        PH_STOP_REL
    } phase_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } ovr_t;

    localparam int SDA_BIT = 8;
    localparam int SCL_BIT = 9;

    function automatic ovr_t phase_ovr(phase_e ph);
        ovr_t o;
        o = '0;
        unique case (ph)
            PH_FLUSH_LOW: o.scl_low = 1'b1;
            PH_BOTH_LOW: begin
                o.scl_low = 1'b1;
                o.sda_low = 1'b1;
            end
            PH_DATA_HOLD: o.sda_low = 1'b1;
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bus_recover_timer.sv
module bus_recover_timer #(
    parameter int HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
    import bus_recover_pkg::*;
#(
    parameter int FLUSH_CNT = 9
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   tick,
    output phase_e phase,
    output logic   done
);
    localparam int FW = (FLUSH_CNT > 1) ? $clog2(FLUSH_CNT) : 1;
    localparam logic [FW-1:0] FLAST = FW'(FLUSH_CNT - 1);

    logic [FW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                idx <= '0;
                if (start) phase <= PH_FLUSH_REL;
            end else if (tick) begin
                unique case (phase)
                    PH_FLUSH_REL: phase <= PH_FLUSH_LOW;
                    PH_FLUSH_LOW: begin
                        if (idx == FLAST) begin
                            phase <= PH_BOTH_LOW;
                            idx   <= '0;
                        end else begin
                            phase <= PH_FLUSH_REL;
                            idx   <= idx + 1'b1;
                        end
                    end
                    PH_BOTH_LOW:  phase <= PH_DATA_HOLD;
                    PH_DATA_HOLD: phase <= PH_STOP_REL;
                    PH_STOP_REL: begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R8: while running, the phase moves only on a timer tick
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !tick) |=> $stable(phase));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/bus_recover_pads.sv
module bus_recover_pads
    import bus_recover_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  ovr_t             ovr,
    output logic [REG_W-1:0] word,
    output logic             scl_low,
    output logic             sda_low
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b == SDA_BIT)      begin : g_sda assign word[b] = ovr.sda_low; end
        else if (b == SCL_BIT) begin : g_scl assign word[b] = ovr.scl_low; end
        else                   begin : g_zero assign word[b] = 1'b0; end
    end

    assign scl_low = word[SCL_BIT];
    assign sda_low = word[SDA_BIT];
endmodule

// File: rtl/bus_recover.sv
module bus_recover
    import bus_recover_pkg::*;
#(
    parameter int HALF_CYC  = 250,
    parameter int FLUSH_CNT = 9,
    parameter int REG_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             scl_low_o,
    output logic             sda_low_o,
    output logic [REG_W-1:0] ovr_word_o
);
    phase_e phase;
    logic   tick;
    logic   run;
    ovr_t   ovr;

    assign run    = (phase != PH_IDLE);
    assign busy_o = run;
    assign ovr    = phase_ovr(phase);

    bus_recover_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(run), .tick(tick)
    );

    bus_recover_seq #(.FLUSH_CNT(FLUSH_CNT)) u_seq (
        .clk(clk), .rst(rst), .start(start_i), .tick(tick),
        .phase(phase), .done(done_o)
    );

    bus_recover_pads #(.REG_W(REG_W)) u_pads (
        .ovr(ovr), .word(ovr_word_o), .scl_low(scl_low_o), .sda_low(sda_low_o)
    );

    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_low_o && !sda_low_o));
    // R5: data is pulled low only while the clock was already low
    a_r5_data_low_after_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low_o) |-> (scl_low_o && $past(scl_low_o)));
    // R6/R7: data is released only while the clock is released
    a_r7_stop_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_low_o) |-> (!scl_low_o && !$past(scl_low_o)));
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/bus_recover_tb.sv
module bus_recover_tb;
    localparam int H     = 3;
    localparam int NF    = 9;
    localparam int W     = 16;
    localparam int STEPS = 2 * NF + 3;
    localparam int TOT   = STEPS * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, scl_low, sda_low;
    logic [W-1:0] word;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bus_recover #(.HALF_CYC(H), .FLUSH_CNT(NF), .REG_W(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
        .scl_low_o(scl_low), .sda_low_o(sda_low), .ovr_word_o(word)
    );

    task automatic check(string req, logic [W+3:0] act, logic [W+3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // packed observation: {busy, done, scl, sda, word}
    function automatic logic [W+3:0] pack_exp(bit b, bit d, bit c, bit s);
        logic [W-1:0] w;
        w = '0;
        w[9] = c;
        w[8] = s;
        return {b, d, c, s, w};
    endfunction

    task automatic run_seq(bit poke);
        @(negedge clk);
        start = 1'b1;
        for (int i = 1; i <= TOT; i++) begin
            @(negedge clk);
            begin
                int k;
                bit c, s;
                string req;
                k = (i - 1) / H;
                if (k < 2 * NF) begin
                    c = (k % 2) == 1; s = 1'b0; req = "R4/R3";
                end else if (k == 2 * NF) begin
                    c = 1'b1; s = 1'b1; req = "R5";
                end else if (k == 2 * NF + 1) begin
                    c = 1'b0; s = 1'b1; req = "R6";
                end else begin
                    c = 1'b0; s = 1'b0; req = "R7";
                end
                if (i == 1) req = "R2";
                if (poke) req = {req, " R8"};
                check(req, {busy, done, scl_low, sda_low, word}, pack_exp(1, 0, c, s));
            end
            start = poke && ((i % 4) == 0);
        end
        @(negedge clk);
        check("R7 done", {busy, done, scl_low, sda_low, word}, pack_exp(0, 1, 0, 0));
        start = 1'b0;
        @(negedge clk);
        check("R7 idle", {busy, done, scl_low, sda_low, word}, pack_exp(0, 0, 0, 0));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {busy, done, scl_low, sda_low, word}, pack_exp(0, 0, 0, 0));
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R1 after reset", {busy, done, scl_low, sda_low, word}, pack_exp(0, 0, 0, 0));
        end
        run_seq(1'b0);
        run_seq(1'b1);
        run_seq(1'b0);
        // R9: no stray bits outside 8 and 9 while idle
        @(negedge clk);
        check("R9 idle word", {busy, done, scl_low, sda_low, word}, pack_exp(0, 0, 0, 0));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule